// File: doc/BRIEF.md
# Dual Operand Stack Unit

This unit holds two independent operand stacks of 64 words each and serves one stack instruction per clock. An 8-bit stack pointer carries a 2-bit bank field in bits [7:6] and a 6-bit word address in bits [5:0]. Each accepted stack instruction can do three things in a fixed order:

1. Read the top entry at the current pointer.
2. Move the word address by a signed step between -4 and +3.
3. Write one word, either at the old address or at the adjusted address.

A control decoder classifies each presented command into one of five actions: `ACT_IDLE`, `ACT_STACK`, `ACT_FAULT`, `ACT_LOAD` and `ACT_RESTORE`.

- `ACT_IDLE` covers three cases: no command, a command from a task other than the emulator task, or the reserved command kind.
- `ACT_STACK` is a legal stack instruction, which commits at the next clock edge.
- `ACT_FAULT` is a stack instruction that would overflow or underflow. The unit raises the error request combinationally in the same cycle, before that instruction can commit, and then drops the instruction.
- `ACT_LOAD` copies the pointer from the B bus.
- `ACT_RESTORE` returns the pointer to the value saved by the last pointer-changing instruction.

Each action lasts a single cycle. The next cycle always goes back to a fresh decode, so every transition leads from the current action to whatever the next command decodes to.

The surrounding datapath supplies write data and takes read data one cycle later. The task scheduler watches the error request and wakes the stack-error task, task 15.

Top module: `dstk_unit`

## Requirements
- R1: After reset, `stk_ptr` is 0x00, `rd_valid` is 0 and `stk_err` is 0 while no command is presented.
- R2: Word address is `stk_ptr[5:0]`. Bit 6 selects which of the two stores is used. Bit 7 is kept in the register but does not select storage. The two stores are independent, and a stack instruction never changes bits [7:6].
- R3: `cmd_step` is a 3-bit two's-complement step. An accepted stack instruction sets the word address to the old address plus the step on the next edge.
- R4: With `cmd_read`=1, `rd_data` shows the entry at the unadjusted address one cycle later, with `rd_valid` high for that cycle. The read sees the contents from before any write made by the same instruction.
- R5: With `cmd_write`=1, `cmd_wdata` is stored at the adjusted address when `cmd_wr_adj`=1. When `cmd_wr_adj`=0 it is stored at the unadjusted address.
- R6: If the old word address plus the step is above 63 or below 0, `stk_err` is high in the same cycle. The pointer, the storage and the saved value are then not updated, and no read result is produced.
- R7: A read with `cmd_ufl_chk`=1 at word address 0 raises `stk_err` and is dropped as in R6. With `cmd_ufl_chk`=0, or with no read, word address 0 is not an error.
- R8: Command kind 1 loads `stk_ptr` from `bus_b`.
- R9: Command kind 2 restores `stk_ptr` to the saved value. The saved value is the pointer as it stood before the last accepted load, or before the last accepted stack instruction with a nonzero step. It is 0x00 after reset.
- R10: With `cmd_emu`=0, a command has no effect on the pointer, the storage or the saved value, gives no read result and raises no error.
- R11: Command kind 3 is ignored. Stack instructions use kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_emu | input | 1 | Command comes from the emulator task |
| cmd_kind | input | 2 | 0 stack, 1 load from bus, 2 restore, 3 reserved |
| cmd_read | input | 1 | Read the top entry |
| cmd_ufl_chk | input | 1 | Treat a read at word address 0 as an error |
| cmd_step | input | 3 | Signed pointer step, -4 to +3 |
| cmd_write | input | 1 | Write `cmd_wdata` |
| cmd_wr_adj | input | 1 | Write at the adjusted address |
| cmd_wdata | input | 16 | Write data |
| bus_b | input | 8 | Pointer load value |
| stk_ptr | output | 8 | Current stack pointer |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | `rd_data` holds a fresh read |
| stk_err | output | 1 | Stack error request, valid in the same cycle as the command |

## Verification
A wrong pointer update appears on `stk_ptr` one edge after the instruction, and it also changes which error checks fire on the following commands. A wrong write address or a wrong store select stays hidden until that cell is read, so the bench fills every cell of both stores and reads them all back, and it also keeps a full model of the storage through a long mixed command stream. A wrong saved value only shows one edge after a restore, so restores are mixed in throughout the stream.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

    typedef enum logic [1:0] {
        CMD_STACK   = 2'd0,
        CMD_LOAD    = 2'd1,
        CMD_RESTORE = 2'd2,
        CMD_RSVD    = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_STACK,
        ACT_FAULT,
        ACT_LOAD,
        ACT_RESTORE
    } act_e;

endpackage

// File: rtl/dstk_step_check.sv
module dstk_step_check #(
    parameter int WORD_AW = 6,
    parameter int STEP_W  = 3
) (
    input  logic [WORD_AW-1:0] cur_word,
    input  logic [STEP_W-1:0]  step,
    input  logic               rd_req,
    input  logic               ufl_chk,
    output logic [WORD_AW-1:0] new_word,
    output logic               step_nz,
    output logic               fault
);
    localparam int SUM_W = WORD_AW + 2;
    localparam int EXT_W = SUM_W - STEP_W;

    logic signed [SUM_W-1:0] sum;
    logic                    over, under, empty_rd;

    always_comb begin
        sum      = $signed({2'b00, cur_word}) + $signed({{EXT_W{step[STEP_W-1]}}, step});
        under    = sum[SUM_W-1];
        over     = !sum[SUM_W-1] && sum[WORD_AW];
        empty_rd = rd_req && ufl_chk && (cur_word == '0);
        fault    = over || under || empty_rd;
        new_word = sum[WORD_AW-1:0];
        step_nz  = (step != '0);
    end

    always_comb begin
        if (!fault) begin
            assert_no_overflow_R6: assert (({1'b0, cur_word} + {{(WORD_AW+1-STEP_W){step[STEP_W-1]}}, step}) <= (WORD_AW+1)'(2**WORD_AW - 1)
                                            || step[STEP_W-1]);
        end
    end

endmodule

// File: rtl/dstk_ptr_reg.sv
module dstk_ptr_reg
    import dstk_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  act_e               act,
    input  logic [WORD_AW-1:0] new_word,
    input  logic               step_nz,
    input  logic [PTR_W-1:0]   load_val,
    output logic [PTR_W-1:0]   ptr
);
    logic [PTR_W-1:0] saved;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            saved <= '0;
        end else begin
            unique case (act)
                ACT_STACK: begin
                    ptr <= {ptr[PTR_W-1:WORD_AW], new_word};
                    if (step_nz) saved <= ptr;
                end
                ACT_LOAD: begin
                    saved <= ptr;
                    ptr   <= load_val;
                end
                ACT_RESTORE: ptr <= saved;
                default: ;
            endcase
        end
    end

    assert_restore_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_RESTORE |=> ptr == $past(saved));

    assert_idle_holds_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE || act == ACT_FAULT) |=> $stable(ptr));

    assert_bank_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_STACK |=> ptr[PTR_W-1:WORD_AW] == $past(ptr[PTR_W-1:WORD_AW]));

endmodule

// File: rtl/dstk_bank_mem.sv
module dstk_bank_mem #(
    parameter int DATA_W    = 16,
    parameter int WORD_AW   = 6,
    parameter int NUM_BANKS = 2,
    parameter int BANK_IW   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [BANK_IW-1:0] bank,
    input  logic [WORD_AW-1:0] rd_addr,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid
);
    localparam int DEPTH = 2 ** WORD_AW;

    logic [DATA_W-1:0] rd_word [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (bank == BANK_IW'(b))) store[wr_addr] <= wr_data;
        end

        assign rd_word[b] = store[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_word[bank];
        end
    end

    assert_rd_valid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

endmodule

// File: rtl/dstk_unit.sv
module dstk_unit
    import dstk_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PTR_W     = 8,
    parameter int WORD_AW   = 6,
    parameter int STEP_W    = 3,
    parameter int NUM_BANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_emu,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_read,
    input  logic              cmd_ufl_chk,
    input  logic [STEP_W-1:0] cmd_step,
    input  logic              cmd_write,
    input  logic              cmd_wr_adj,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [PTR_W-1:0]  bus_b,
    output logic [PTR_W-1:0]  stk_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              stk_err
);
    localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    act_e               act;
    logic [WORD_AW-1:0] cur_word, new_word, wr_addr;
    logic [BANK_IW-1:0] bank;
    logic               step_nz, fault;

    assign cur_word = stk_ptr[WORD_AW-1:0];
    assign bank     = stk_ptr[WORD_AW +: BANK_IW];

    dstk_step_check #(.WORD_AW(WORD_AW), .STEP_W(STEP_W)) u_check (
        .cur_word (cur_word),
        .step     (cmd_step),
        .rd_req   (cmd_read),
        .ufl_chk  (cmd_ufl_chk),
        .new_word (new_word),
        .step_nz  (step_nz),
        .fault    (fault)
    );

    always_comb begin
        act = ACT_IDLE;
        if (cmd_valid && cmd_emu) begin
            unique case (cmd_kind_e'(cmd_kind))
                CMD_STACK:   act = fault ? ACT_FAULT : ACT_STACK;
                CMD_LOAD:    act = ACT_LOAD;
                CMD_RESTORE: act = ACT_RESTORE;
                default:     act = ACT_IDLE;
            endcase
        end
    end

    always_comb begin
        stk_err = (act == ACT_FAULT);
        wr_addr = cmd_wr_adj ? new_word : cur_word;
    end

    dstk_ptr_reg #(.PTR_W(PTR_W), .WORD_AW(WORD_AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .new_word (new_word),
        .step_nz  (step_nz),
        .load_val (bus_b),
        .ptr      (stk_ptr)
    );

    dstk_bank_mem #(
        .DATA_W(DATA_W), .WORD_AW(WORD_AW), .NUM_BANKS(NUM_BANKS), .BANK_IW(BANK_IW)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (act == ACT_STACK && cmd_read),
        .bank     (bank),
        .rd_addr  (cur_word),
        .wr_en    (act == ACT_STACK && cmd_write),
        .wr_addr  (wr_addr),
        .wr_data  (cmd_wdata),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assert_fault_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> ($stable(stk_ptr) && !rd_valid));

    assert_foreign_task_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_emu) |-> !stk_err);

endmodule

// File: tb/dstk_unit_tb_top.sv
module dstk_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, cmd_emu = 0, cmd_read = 0, cmd_ufl_chk = 0;
    logic        cmd_write = 0, cmd_wr_adj = 0;
    logic [1:0]  cmd_kind = 0;
    logic [2:0]  cmd_step = 0;
    logic [15:0] cmd_wdata = 0;
    logic [7:0]  bus_b = 0;
    logic [7:0]  stk_ptr;
    logic [15:0] rd_data;
    logic        rd_valid, stk_err;

    int checks = 0, failures = 0;
    logic [15:0] mem_m [128];
    logic [7:0]  ptr_m = 0, saved_m = 0;
    logic [31:0] rng = 32'h1234_5678;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dstk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_emu(cmd_emu),
        .cmd_kind(cmd_kind), .cmd_read(cmd_read), .cmd_ufl_chk(cmd_ufl_chk),
        .cmd_step(cmd_step), .cmd_write(cmd_write), .cmd_wr_adj(cmd_wr_adj),
        .cmd_wdata(cmd_wdata), .bus_b(bus_b), .stk_ptr(stk_ptr),
        .rd_data(rd_data), .rd_valid(rd_valid), .stk_err(stk_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    // Drive one command at a falling edge, check the same-cycle error,
    // update the model, then check registered outputs at the next falling edge.
    task automatic issue(input bit v, input bit emu, input logic [1:0] kind,
                         input bit rd, input bit chk, input int step,
                         input bit wr, input bit adj, input logic [15:0] wd,
                         input logic [7:0] bus, input string tag);
        int  word, sum;
        bit  acc, err_e, rv_e;
        logic [15:0] rd_e;
        logic [6:0]  idx;
        cmd_valid = v; cmd_emu = emu; cmd_kind = kind; cmd_read = rd;
        cmd_ufl_chk = chk; cmd_step = 3'(step); cmd_write = wr; cmd_wr_adj = adj;
        cmd_wdata = wd; bus_b = bus;
        word  = int'(ptr_m[5:0]);
        sum   = word + step;
        acc   = v && emu;
        err_e = acc && kind == 2'd0 && (sum > 63 || sum < 0 || (rd && chk && word == 0));
        rv_e  = acc && !err_e && kind == 2'd0 && rd;
        rd_e  = 16'h0;
        #1;
        check(stk_err == err_e, err_e ? "R6" : tag, "stk_err", int'(stk_err), int'(err_e));
        if (acc && !err_e) begin
            unique case (kind)
                2'd0: begin
                    idx = {ptr_m[6], ptr_m[5:0]};
                    if (rd) rd_e = mem_m[idx];
                    if (wr) mem_m[{ptr_m[6], adj ? 6'(sum) : ptr_m[5:0]}] = wd;
                    if (step != 0) saved_m = ptr_m;
                    ptr_m = {ptr_m[7:6], 6'(sum)};
                end
                2'd1: begin saved_m = ptr_m; ptr_m = bus; end
                2'd2: ptr_m = saved_m;
                default: ;
            endcase
        end
        @(negedge clk);
        check(stk_ptr == ptr_m, tag, "stk_ptr", int'(stk_ptr), int'(ptr_m));
        check(rd_valid == rv_e, tag, "rd_valid", int'(rd_valid), int'(rv_e));
        if (rv_e) check(rd_data == rd_e, "R4", "rd_data", int'(rd_data), int'(rd_e));
        cmd_valid = 0;
    endtask

    function automatic logic [15:0] pat(input int b, input int a);
        return 16'((b * 16'h3A51) ^ (a * 16'h0107) ^ 16'h5C00);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(stk_ptr == 8'h00, "R1", "reset ptr", int'(stk_ptr), 0);
        check(rd_valid == 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
        check(stk_err == 1'b0, "R1", "reset stk_err", int'(stk_err), 0);

        // R5 and R2: fill both stores by pushes writing at the adjusted address
        for (int b = 0; b < 2; b++) begin
            issue(1, 1, 2'd1, 0, 0, 0, 0, 0, 0, 8'(b << 6), "R8");
            issue(1, 1, 2'd0, 0, 0, 0, 1, 0, pat(b, 0), 0, "R5");
            for (int a = 1; a < 64; a++)
                issue(1, 1, 2'd0, 0, 0, 1, 1, 1, pat(b, a), 0, "R5");
        end
        // R4 and R2: read everything back, top down; bit 7 set for bank 0 aliasing
        for (int b = 0; b < 2; b++) begin
            issue(1, 1, 2'd1, 0, 0, 0, 0, 0, 0, 8'((b << 6) | 63 | (b == 0 ? 128 : 0)), "R2");
            for (int a = 63; a > 0; a--)
                issue(1, 1, 2'd0, 1, 1, -1, 0, 0, 0, 0, "R4");
            issue(1, 1, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R7");
        end

        // R3 and R6: sweep every word address against every step
        for (int w = 0; w < 64; w++) begin
            for (int s = -4; s < 4; s++) begin
                issue(1, 1, 2'd1, 0, 0, 0, 0, 0, 0, 8'(((w & 1) << 6) | w), "R8");
                issue(1, 1, 2'd0, 0, 0, s, 0, 0, 0, 0, "R3");
            end
        end

        // R7 directed at word address 0
        issue(1, 1, 2'd1, 0, 0, 0, 0, 0, 0, 8'h40, "R8");
        issue(1, 1, 2'd0, 1, 1, 0, 0, 0, 0, 0, "R7");
        issue(1, 1, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R7");
        issue(1, 1, 2'd0, 0, 1, 2, 0, 0, 0, 0, "R7");
        // R4 read-before-write at the same address
        issue(1, 1, 2'd0, 1, 0, 0, 1, 0, 16'hBEEF, 0, "R4");
        issue(1, 1, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R4");
        // R9 restore after a step, R10 foreign task, R11 reserved kind
        issue(1, 1, 2'd0, 0, 0, 3, 0, 0, 0, 0, "R3");
        issue(1, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, "R9");
        issue(1, 0, 2'd0, 1, 0, 1, 1, 1, 16'h1111, 0, "R10");
        issue(1, 0, 2'd1, 0, 0, 0, 0, 0, 0, 8'hFF, "R10");
        issue(1, 1, 2'd3, 1, 0, 1, 1, 1, 16'h2222, 8'hFF, "R11");
        issue(1, 1, 2'd0, 1, 0, 0, 0, 0, 0, 0, "R10");

        // Mixed stream of all command kinds
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] k;
            rng = next_rng(rng);
            k = (rng[3:0] < 11) ? 2'd0 : (rng[3:0] < 13) ? 2'd1 : (rng[3:0] < 15) ? 2'd2 : 2'd3;
            issue(rng[4] | rng[5], rng[8:6] != 0, k, rng[9], rng[10], int'($signed(rng[13:11])),
                  rng[14], rng[15], rng[31:16], rng[27:20], "R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule